// File: doc/BRIEF.md
# Binarized 3x3 Convolution Bank

This block takes one square feature map whose entries are bipolar (+1 or -1) and convolves it with a bank of 3x3 filters whose taps are single bits. Every filter and every output position is evaluated in parallel, with no multipliers. Each weight bit only decides whether the neighbouring input value is added to or taken away from the window sum. Each sum is then reduced to a bipolar value by its sign. Any tap that falls outside the map reads zero, so each output map has the same size as the input map.

The filter bank is a constant parameter. A one-cycle `start` pulse captures the results of the combinational datapath into output registers. `valid` pulses one clock later, and the outputs then hold until the next `start`. The block is meant to sit between a producer of bipolar maps and a downstream pooling or accumulation stage.

Top module: `bconv3x3_bank`

## Requirements
- R1: Taps whose input position lies outside the MAPxMAP map add nothing to the window sum, and every output map is MAPxMAP.
- R2: The output at row r, column c of filter f sums, over kr and kc in 0..2, the term ±x(r+kr-1, c+kc-1). Weight bit f*9+kr*3+kc of `WEIGHTS` set to 1 gives +x, and set to 0 gives -x.
- R3: An output entry is +1 only when its window sum is strictly positive. A sum of zero or less gives -1.
- R4: Bipolar codes are 2'b01 for +1 and 2'b11 for -1. Input entry (r,c) sits at bits (r*MAP+c)*2 +: 2. Output entry (f,r,c) sits at bits ((f*MAP+r)*MAP+c)*2 +: 2.
- R5: All N_FILT output maps are produced together from the same captured input map.
- R6: `valid` is high in exactly the cycle after each cycle with `start` high. At that point the outputs hold the result for the map present when `start` was sampled, and back-to-back starts each produce their own result.
- R7: While `start` is low, changes on `fmap_in` have no effect, and `fmap_out` keeps its value.
- R8: During and right after reset, `valid` is 0 and every output entry is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the convolution of `fmap_in` |
| fmap_in | input | MAP*MAP*2 | Input bipolar map, row-major |
| valid | output | 1 | One-cycle pulse after each start |
| fmap_out | output | N_FILT*MAP*MAP*2 | Registered output maps, filter-major then row-major |

## Verification
The assertions assume that every input entry present when `start` is high is a legal code, 2'b01 or 2'b11. One assertion checks this assumption directly. Another relies on it: a window lying fully inside the map has nine odd terms, so its sum must be odd and can never be zero. The bench keeps to this assumption by building all of its maps from the two legal codes only. Its hex vectors use just the digits 5, 7, D and F, so every 2-bit field is 01 or 11.

// File: rtl/bnnconv_pkg.sv
package bnnconv_pkg;
  localparam int TAPS  = 9;
  localparam int SUM_W = $clog2(TAPS + 1) + 1;
  localparam logic [1:0] BIP_POS = 2'b01;
  localparam logic [1:0] BIP_NEG = 2'b11;

  // Signed contribution of one tap: weight 1 adds, weight 0 subtracts.
  function automatic logic signed [SUM_W-1:0] tap_term(input logic w, input logic [1:0] v);
    logic signed [SUM_W-1:0] x;
    x = {{(SUM_W-2){v[1]}}, v};
    return w ? x : -x;
  endfunction

  // Sign binarization; zero maps to the negative code.
  function automatic logic [1:0] bin_code(input logic signed [SUM_W-1:0] s);
    return (s > 0) ? BIP_POS : BIP_NEG;
  endfunction

  function automatic logic code_legal(input logic [1:0] v);
    return (v == BIP_POS) || (v == BIP_NEG);
  endfunction
endpackage

// File: rtl/bconv_pad.sv
module bconv_pad #(
  parameter int MAP = 8
) (
  input  logic [MAP*MAP*2-1:0]         fmap,
  output logic [(MAP+2)*(MAP+2)*2-1:0] pad_flat,
  output logic                         in_legal
);
  localparam int PW = MAP + 2;

  always_comb begin
    pad_flat = '0;
    in_legal = 1'b1;
    for (int r = 0; r < MAP; r++) begin
      for (int c = 0; c < MAP; c++) begin
        pad_flat[((r+1)*PW + (c+1))*2 +: 2] = fmap[(r*MAP + c)*2 +: 2];
        in_legal = in_legal & bnnconv_pkg::code_legal(fmap[(r*MAP + c)*2 +: 2]);
      end
    end
  end
endmodule

// File: rtl/bconv_filter.sv
module bconv_filter #(
  parameter int         MAP = 8,
  parameter logic [8:0] W   = 9'h1FF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_legal,
  input  logic [(MAP+2)*(MAP+2)*2-1:0] pad_flat,
  output logic [MAP*MAP*2-1:0]         bin_map
);
  import bnnconv_pkg::*;
  localparam int PW = MAP + 2;

  logic signed [SUM_W-1:0] sums [MAP*MAP];
  logic                    interior_odd;

  always_comb begin
    for (int r = 0; r < MAP; r++) begin
      for (int c = 0; c < MAP; c++) begin
        logic signed [SUM_W-1:0] acc;
        acc = '0;
        for (int kr = 0; kr < 3; kr++) begin
          for (int kc = 0; kc < 3; kc++) begin
            acc = acc + tap_term(W[kr*3 + kc], pad_flat[((r+kr)*PW + (c+kc))*2 +: 2]);
          end
        end
        sums[r*MAP + c] = acc;
        bin_map[(r*MAP + c)*2 +: 2] = bin_code(acc);
      end
    end
  end

  // Event wire for the checks: every fully interior window has an odd sum.
  always_comb begin
    interior_odd = 1'b1;
    for (int r = 1; r < MAP-1; r++) begin
      for (int c = 1; c < MAP-1; c++) begin
        interior_odd = interior_odd & sums[r*MAP + c][0];
      end
    end
  end

  // R3: with legal inputs, nine odd terms never sum to zero inside the map
  a_r3_interior_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    in_legal |-> interior_odd);

  // R1: a corner window has only four taps, so its sum stays within +-4
  a_r1_corner_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_legal |-> (sums[0] <= 4 && sums[0] >= -4));
endmodule

// File: rtl/bconv3x3_bank.sv
module bconv3x3_bank #(
  parameter int                  N_FILT  = 16,
  parameter int                  MAP     = 8,
  parameter logic [N_FILT*9-1:0] WEIGHTS = {9'h0C3, 9'h15A, 9'h1E0, 9'h027,
                                            9'h0B4, 9'h16D, 9'h099, 9'h1C2,
                                            9'h03E, 9'h145, 9'h0AA, 9'h155,
                                            9'h111, 9'h0EE, 9'h000, 9'h1FF}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [MAP*MAP*2-1:0]        fmap_in,
  output logic                        valid,
  output logic [N_FILT*MAP*MAP*2-1:0] fmap_out
);
  localparam int MW  = MAP * MAP * 2;
  localparam int PFW = (MAP + 2) * (MAP + 2) * 2;
  localparam int OW  = N_FILT * MW;

  logic [PFW-1:0] pad_flat;
  logic           in_legal;
  logic [OW-1:0]  bin_all;
  logic [OW-1:0]  out_q;
  logic           valid_q;
  logic           out_codes_ok;

  bconv_pad #(.MAP(MAP)) u_pad (
    .fmap     (fmap_in),
    .pad_flat (pad_flat),
    .in_legal (in_legal)
  );

  for (genvar f = 0; f < N_FILT; f++) begin : g_filt
    bconv_filter #(.MAP(MAP), .W(WEIGHTS[f*9 +: 9])) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_legal (in_legal),
      .pad_flat (pad_flat),
      .bin_map  (bin_all[f*MW +: MW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '1;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start;
      if (start) out_q <= bin_all;
    end
  end

  assign valid    = valid_q;
  assign fmap_out = out_q;

  always_comb begin
    out_codes_ok = 1'b1;
    for (int i = 0; i < OW/2; i++) begin
      out_codes_ok = out_codes_ok & bnnconv_pkg::code_legal(out_q[i*2 +: 2]);
    end
  end

  // R4: only legal input codes are accepted at capture
  a_r4_input_legal: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> in_legal);

  // R4: every registered output entry carries a legal bipolar code
  a_r4_out_codes: assert property (@(posedge clk) disable iff (!rst_n)
    out_codes_ok);

  // R6: valid follows start by exactly one clock
  a_r6_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  // R7: outputs hold while start is low
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(fmap_out));
endmodule

// File: tb/tb_bconv3x3_bank.sv
module tb_bconv3x3_bank;
  localparam int NF  = 16;
  localparam int MAP = 8;
  localparam int MW  = MAP * MAP * 2;
  localparam int NV  = 6;
  localparam logic [NF*9-1:0] TB_W = {9'h1B6, 9'h049, 9'h0F0, 9'h10F,
                                      9'h1AA, 9'h055, 9'h124, 9'h0DB,
                                      9'h038, 9'h1C7, 9'h16B, 9'h094,
                                      9'h010, 9'h1EF, 9'h000, 9'h1FF};
  localparam logic [MW-1:0] VEC [NV] = '{
    {32{4'h5}},
    {32{4'hF}},
    {4{16'h7777, 16'hDDDD}},
    {4{16'hFFFF, 16'h5555}},
    128'hF5D7_5FF7_D55F_7DF5_57FD_F75D_5F7F_D5F5,
    128'h7DF5_F757_DD5F_57F7_FD75_5FD7_7F5D_D57F
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [MW-1:0]     fmap_in = '0;
  logic              valid;
  logic [NF*MW-1:0]  fmap_out;

  int n_chk = 0;
  int n_bad = 0;
  int zero_hits = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bconv3x3_bank #(.N_FILT(NF), .MAP(MAP), .WEIGHTS(TB_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fmap_in(fmap_in),
    .valid(valid), .fmap_out(fmap_out)
  );

  function automatic int win_sum(logic [MW-1:0] m, logic [8:0] w, int r, int c);
    int s = 0;
    for (int dr = -1; dr <= 1; dr++) begin
      for (int dc = -1; dc <= 1; dc++) begin
        int rr = r + dr;
        int cc = c + dc;
        if (rr >= 0 && rr < MAP && cc >= 0 && cc < MAP) begin
          int v = (m[(rr*MAP+cc)*2 +: 2] == 2'b01) ? 1 : -1;
          if (w[(dr+1)*3 + (dc+1)]) s += v; else s -= v;
        end
      end
    end
    return s;
  endfunction

  function automatic logic [MW-1:0] exp_map(logic [MW-1:0] m, int f);
    logic [MW-1:0] e;
    for (int r = 0; r < MAP; r++)
      for (int c = 0; c < MAP; c++)
        e[(r*MAP+c)*2 +: 2] = (win_sum(m, TB_W[f*9 +: 9], r, c) > 0) ? 2'b01 : 2'b11;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [MW-1:0] m, input string req);
    for (int f = 0; f < NF; f++) begin
      logic [MW-1:0] e = exp_map(m, f);
      chk(fmap_out[f*MW +: MW] === e, req, fmap_out[f*MW +: MW], e);
    end
  endtask

  task automatic pulse(input logic [MW-1:0] m);
    @(negedge clk);
    fmap_in = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [MW-1:0] single;
    logic [MW-1:0] held;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R8 valid in reset", {127'b0, valid}, '0);
    chk(fmap_out === '1, "R8 outputs in reset", fmap_out[MW-1:0], '1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && fmap_out === '1, "R8 after reset", fmap_out[MW-1:0], '1);

    // table walk: R1 R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v]);
      chk(valid === 1'b1, "R6 valid one cycle after start", {127'b0, valid}, 1);
      check_all(VEC[v], "R1 R2 R3 R4 R5 table vector");
      for (int f = 0; f < NF; f++)
        for (int r = 0; r < MAP; r++)
          for (int c = 0; c < MAP; c++)
            if (win_sum(VEC[v], TB_W[f*9 +: 9], r, c) == 0) begin
              zero_hits++;
              chk(fmap_out[((f*MAP+r)*MAP+c)*2 +: 2] === 2'b11, "R3 zero sum gives -1",
                  {126'b0, fmap_out[((f*MAP+r)*MAP+c)*2 +: 2]}, {126'b0, 2'b11});
            end
      @(negedge clk);
      chk(valid === 1'b0, "R6 valid is a single pulse", {127'b0, valid}, '0);
    end
    chk(zero_hits > 0, "R3 zero-sum case exercised", MW'(zero_hits), 1);

    // R1 R2: single +1 pixel on a corner and in the interior
    single = '1;
    single[0 +: 2] = 2'b01;
    single[(4*MAP+3)*2 +: 2] = 2'b01;
    pulse(single);
    check_all(single, "R1 R2 single pixels");

    // R7: input changes without start are ignored
    held = fmap_out[MW-1:0];
    @(negedge clk);
    fmap_in = VEC[2];
    repeat (3) @(negedge clk);
    chk(valid === 1'b0, "R7 no valid without start", {127'b0, valid}, '0);
    check_all(single, "R7 outputs hold");
    chk(fmap_out[MW-1:0] === held, "R7 filter 0 unchanged", fmap_out[MW-1:0], held);

    // R6: back-to-back starts
    @(negedge clk);
    fmap_in = VEC[4];
    start = 1'b1;
    @(negedge clk);
    check_all(VEC[4], "R6 first of back-to-back");
    fmap_in = VEC[5];
    @(negedge clk);
    start = 1'b0;
    chk(valid === 1'b1, "R6 valid stays for second start", {127'b0, valid}, 1);
    check_all(VEC[5], "R6 second of back-to-back");
    @(negedge clk);
    chk(valid === 1'b0, "R6 valid drops", {127'b0, valid}, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule